// File: doc/BRIEF.md
# Video Processor CPU Port with Paced Memory Access

This block is the processor-facing side of a tile-based video display processor. The host writes bytes to two ports, chosen by a select line. The control port takes bytes in pairs. Each pair either loads a video-memory address or writes one internal register. On the later variant, a pair can also select the colour memory. The data port reads and writes video memory through a one-byte staging buffer. Every memory operation is turned into one pending access. That access is carried out during a free memory slot that the display fetch logic grants.

A pending access may not run at once. Once it is queued, it has to wait a fixed number of access cycles before any granted slot can serve it. That wait is 7 cycles on the later variant and 8 on the classic one. One access cycle equals one clock. Loading an address queues a read straight away, so the staging buffer already holds the byte when the host asks for it. A data-port read hands over the staged byte and queues the next read. Every served access steps the 14-bit address by one.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset, no memory strobe is active when no access is pending, `cram_sel` and `reg_we` are 0, `cpu_rdata` is 0, `vram_addr` is 0 and the control port expects the first byte of a pair.
- R2: With `cpu_ctrl`=1, the first written byte is held. A second byte with bit 7 = 0 sets the address to {second[5:0], first} and queues a read.
- R3: A second control byte with bit 7 = 1 pulses `reg_we` for exactly one cycle, in the cycle after the write. `reg_val` is the first byte. `reg_idx` is second[3:0] on the later variant and second[2:0] on the classic variant.
- R4: On the later variant, a second control byte with bits 7 and 6 both set raises `cram_sel`. It writes no register, leaves the address unchanged and queues nothing.
- R5: A data-port write (`cpu_ctrl`=0) stores the byte in the staging buffer and queues a write. When that write is served, `vram_we` is high with the buffer on `vram_wdata` at the current address. The address then steps by one.
- R6: `cpu_rdata` always shows the staging buffer. A data-port read queues a read. When that read is served, `vram_re` is high, the buffer takes `vram_rdata`, and the address steps by one.
- R7: An access queued by a write or read sampled at clock edge E can be served no earlier than the cycle that begins D edges after E. D is 7 on the later variant and 8 on the classic variant. Queuing again replaces the pending access and restarts the wait.
- R8: A memory strobe needs `slot_grant`. A pending access is kept until a granted slot arrives. A slot with nothing pending produces no strobe. After an access is served, nothing is pending.
- R9: Any data-port access, and any second control byte, clears `cram_sel` and resets the control port to expect a first byte.
- R10: A granted slot in a cycle that also carries a host write or data-port read is not used. At most one of `vram_we` and `vram_re` is high.
- R11: The address wraps from 0x3FFF to 0x0000 when it steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one access cycle per clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ctrl | input | 1 | Port select: 1 control port, 0 data port |
| cpu_wr | input | 1 | Host write strobe |
| cpu_rd | input | 1 | Host read strobe (acts on the data port) |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Staging buffer contents |
| slot_grant | input | 1 | External memory slot available this cycle |
| vram_addr | output | 14 | Video memory address |
| vram_we | output | 1 | Video memory write strobe |
| vram_re | output | 1 | Video memory read strobe |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data, valid while `vram_re` is high |
| reg_we | output | 1 | Internal register write pulse |
| reg_idx | output | 4 | Register index |
| reg_val | output | 8 | Register value |
| cram_sel | output | 1 | Colour memory selected |

## Verification
The bench times every served access to the exact cycle, both at the first cycle that is allowed and at later ones.

- **Short wait.** A design that counts the wait one cycle short strobes early and is flagged.
- **Wait not restarted.** A second data write during the wait must supersede the first. A design that does not restart the wait serves the stale byte early.
- **Slot taken during a host strobe.** A host strobe placed on the very cycle the wait expires must cancel that slot. Using the slot there would produce an extra strobe.
- **Control-port state.** A lone control byte followed by a data write must reset the pairing. If it does not, the next address pair lands on the wrong address. A colour-memory select must leave the address unchanged.
- **Address edge cases.** The bench checks address wrap-around at 0x3FFF, and register-index masking on a classic-variant instance.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

    localparam int unsigned ADDR_W = 14;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = 4;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        logic              phase;
        logic [BYTE_W-1:0] first;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] rbuf;
        acc_e              pend;
        logic              cram;
        logic              reg_we;
        logic [IDX_W-1:0]  reg_idx;
        logic [BYTE_W-1:0] reg_val;
    } port_state_t;

endpackage

// File: rtl/vdp_ctrl_decode.sv
module vdp_ctrl_decode
    import vdp_port_pkg::*;
#(
    parameter bit LATER_VARIANT = 1'b1
) (
    input  logic [BYTE_W-1:0] first_b,
    input  logic [BYTE_W-1:0] second_b,
    output logic              is_reg,
    output logic              is_cram,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned HI_W = ADDR_W - BYTE_W;

    assign addr = {second_b[HI_W-1:0], first_b};

    generate
        if (LATER_VARIANT) begin : g_later
            assign is_cram = second_b[7] & second_b[6];
            assign idx     = second_b[IDX_W-1:0];
        end else begin : g_classic
            assign is_cram = 1'b0;
            assign idx     = {1'b0, second_b[IDX_W-2:0]};
        end
    endgenerate

    assign is_reg = second_b[7] & ~is_cram;

endmodule

// File: rtl/vdp_access_timer.sv
module vdp_access_timer #(
    parameter int unsigned LOAD_VAL = 7,
    localparam int unsigned CNT_W   = $clog2(LOAD_VAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(LOAD_VAL);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
    import vdp_port_pkg::*;
#(
    parameter bit          LATER_VARIANT = 1'b1,
    parameter int unsigned WAIT_LATER    = 7,
    parameter int unsigned WAIT_CLASSIC  = 8,
    localparam int unsigned WAIT_CYC     = LATER_VARIANT ? WAIT_LATER : WAIT_CLASSIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ctrl,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              slot_grant,
    output logic [ADDR_W-1:0] vram_addr,
    output logic              vram_we,
    output logic              vram_re,
    output logic [BYTE_W-1:0] vram_wdata,
    input  logic [BYTE_W-1:0] vram_rdata,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [BYTE_W-1:0] reg_val,
    output logic              cram_sel
);
    port_state_t s_d, s_q;

    logic              ctrl_wr, data_wr, data_rd, cpu_act;
    logic              serve, timer_load, timer_ready;
    logic              dec_reg, dec_cram;
    logic [IDX_W-1:0]  dec_idx;
    logic [ADDR_W-1:0] dec_addr;

    vdp_ctrl_decode #(.LATER_VARIANT(LATER_VARIANT)) u_dec (
        .first_b  (s_q.first),
        .second_b (cpu_wdata),
        .is_reg   (dec_reg),
        .is_cram  (dec_cram),
        .idx      (dec_idx),
        .addr     (dec_addr)
    );

    vdp_access_timer #(.LOAD_VAL(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .ready (timer_ready)
    );

    assign ctrl_wr = cpu_wr & cpu_ctrl;
    assign data_wr = cpu_wr & ~cpu_ctrl;
    assign data_rd = cpu_rd & ~cpu_wr & ~cpu_ctrl;
    assign cpu_act = ctrl_wr | data_wr | data_rd;

    // A slot is taken only when the wait has run out and the host is quiet.
    assign serve = slot_grant & timer_ready & (s_q.pend != ACC_NONE) & ~cpu_act;

    always_comb begin
        s_d        = s_q;
        s_d.reg_we = 1'b0;
        timer_load = 1'b0;

        if (serve) begin
            if (s_q.pend == ACC_READ) s_d.rbuf = vram_rdata;
            s_d.addr = s_q.addr + 1'b1;
            s_d.pend = ACC_NONE;
        end

        if (data_wr) begin
            s_d.rbuf   = cpu_wdata;
            s_d.pend   = ACC_WRITE;
            s_d.phase  = 1'b0;
            s_d.cram   = 1'b0;
            timer_load = 1'b1;
        end else if (data_rd) begin
            s_d.pend   = ACC_READ;
            s_d.phase  = 1'b0;
            s_d.cram   = 1'b0;
            timer_load = 1'b1;
        end else if (ctrl_wr) begin
            if (!s_q.phase) begin
                s_d.first = cpu_wdata;
                s_d.phase = 1'b1;
            end else begin
                s_d.phase = 1'b0;
                s_d.cram  = 1'b0;
                if (dec_cram) begin
                    s_d.cram = 1'b1;
                end else if (dec_reg) begin
                    s_d.reg_we  = 1'b1;
                    s_d.reg_idx = dec_idx;
                    s_d.reg_val = s_q.first;
                end else begin
                    s_d.addr   = dec_addr;
                    s_d.pend   = ACC_READ;
                    timer_load = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: 1'b0, first: '0, addr: '0, rbuf: '0, pend: ACC_NONE,
                     cram: 1'b0, reg_we: 1'b0, reg_idx: '0, reg_val: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_rdata  = s_q.rbuf;
    assign vram_addr  = s_q.addr;
    assign vram_wdata = s_q.rbuf;
    assign vram_we    = serve & (s_q.pend == ACC_WRITE);
    assign vram_re    = serve & (s_q.pend == ACC_READ);
    assign reg_we     = s_q.reg_we;
    assign reg_idx    = s_q.reg_idx;
    assign reg_val    = s_q.reg_val;
    assign cram_sel   = s_q.cram;

endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk #(
    parameter int unsigned WAIT_CYC = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ctrl,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic        slot_grant,
    input logic [13:0] vram_addr,
    input logic        vram_we,
    input logic        vram_re,
    input logic        reg_we,
    input logic        cram_sel
);
    localparam int unsigned SW = $clog2(WAIT_CYC + 2) + 1;

    logic [SW-1:0] since_q;
    logic          strobe;

    assign strobe = vram_we | vram_re;

    // Cycles since the last data-port access, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_q <= '1;
        else if ((cpu_wr | cpu_rd) & ~cpu_ctrl) since_q <= '0;
        else if (since_q != '1)            since_q <= since_q + 1'b1;
    end

    // R8
    strobe_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> slot_grant);

    // R10
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vram_we, vram_re}));

    // R7
    wait_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (since_q >= SW'(WAIT_CYC)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (vram_addr == $past(vram_addr) + 14'd1));

    // R8
    pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !(vram_we | vram_re));

    // R3
    reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    cram_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cram_sel) |-> !reg_we);

endmodule

bind vdp_cpu_port vdp_cpu_port_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ctrl   (cpu_ctrl),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .slot_grant (slot_grant),
    .vram_addr  (vram_addr),
    .vram_we    (vram_we),
    .vram_re    (vram_re),
    .reg_we     (reg_we),
    .cram_sel   (cram_sel)
);

// File: tb/vdp_cpu_port_tb.sv
module vdp_cpu_port_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          wr;
        logic [13:0] addr;
        logic [7:0]  data;
        int          cyc;
        string       req;
    } acc_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ctrl = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0, slot_grant = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata, vram_wdata, vram_rdata, reg_val;
    logic [13:0] vram_addr;
    logic        vram_we, vram_re, reg_we, cram_sel;
    logic [3:0]  reg_idx;

    logic [7:0]  c_rdata, c_wdata, c_vrd, c_rval;
    logic [13:0] c_addr;
    logic        c_we, c_re, c_rwe, c_cram;
    logic [3:0]  c_ridx;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    acc_item_t sb[$];
    acc_item_t it;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign vram_rdata = vram_addr[7:0] ^ 8'h5A;
    assign c_vrd      = c_addr[7:0] ^ 8'h5A;

    vdp_cpu_port dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_ctrl(cpu_ctrl), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .slot_grant(slot_grant),
        .vram_addr(vram_addr), .vram_we(vram_we), .vram_re(vram_re),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_val(reg_val), .cram_sel(cram_sel)
    );

    vdp_cpu_port #(.LATER_VARIANT(1'b0)) dut_classic_i (
        .clk(clk), .rst_n(rst_n), .cpu_ctrl(cpu_ctrl), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(c_rdata), .slot_grant(slot_grant),
        .vram_addr(c_addr), .vram_we(c_we), .vram_re(c_re),
        .vram_wdata(c_wdata), .vram_rdata(c_vrd), .reg_we(c_rwe),
        .reg_idx(c_ridx), .reg_val(c_rval), .cram_sel(c_cram)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input bit wr, input logic [13:0] a, input logic [7:0] d,
                        input int c, input string req);
        acc_item_t x;
        x.wr = wr; x.addr = a; x.data = d; x.cyc = c; x.req = req;
        sb.push_back(x);
    endtask

    // Starts and ends at one time unit after a rising edge.
    task automatic cpu_op(input bit ctrl, input bit wr, input logic [7:0] d,
                          output int e, output logic [7:0] rd_s);
        cpu_ctrl = ctrl; cpu_wr = wr; cpu_rd = ~wr; cpu_wdata = d;
        @(negedge clk);
        rd_s = cpu_rdata;
        @(posedge clk); #1;
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        e = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    // Scoreboard monitor: every memory strobe must match the next expected access.
    always @(negedge clk) begin
        if (rst_n && (vram_we || vram_re)) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected strobe we=%0b re=%0b addr=%0h, expected none",
                         vram_we, vram_re, vram_addr);
            end else begin
                it = sb.pop_front();
                chk({it.req, " cycle"}, cyc, it.cyc);
                chk({it.req, " kind"}, {31'd0, vram_we}, {31'd0, it.wr});
                chk({it.req, " addr"}, {18'd0, vram_addr}, {18'd0, it.addr});
                if (it.wr) chk({it.req, " data"}, {24'd0, vram_wdata}, {24'd0, it.data});
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int e, e2;
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reg_we", {31'd0, reg_we}, 0);
        chk("R1 cram_sel", {31'd0, cram_sel}, 0);
        chk("R1 strobes", {30'd0, vram_we, vram_re}, 0);
        chk("R1 rdata", {24'd0, cpu_rdata}, 0);
        chk("R1 addr", {18'd0, vram_addr}, 0);
        @(posedge clk); #1;
        slot_grant = 1'b1;

        // R2 address setup queues a read; R6 data reads
        cpu_op(1, 1, 8'h34, e, rd);
        cpu_op(1, 1, 8'h12, e, rd);
        push(0, 14'h1234, 8'h00, e + 7, "R2");
        idle(10);
        cpu_op(0, 0, 8'h00, e, rd);
        chk("R6 rdata", {24'd0, rd}, 32'h6E);
        push(0, 14'h1235, 8'h00, e + 7, "R6");
        idle(10);
        cpu_op(0, 0, 8'h00, e, rd);
        chk("R6 rdata2", {24'd0, rd}, 32'h6F);
        push(0, 14'h1236, 8'h00, e + 7, "R6");
        idle(10);

        // R5 data write
        cpu_op(0, 1, 8'hA5, e, rd);
        push(1, 14'h1237, 8'hA5, e + 7, "R5");
        idle(10);

        // R7 requeue restarts the wait
        cpu_op(0, 1, 8'h11, e, rd);
        idle(3);
        cpu_op(0, 1, 8'h22, e, rd);
        push(1, 14'h1238, 8'h22, e + 7, "R7");
        idle(10);

        // R8 access held until a slot is granted
        slot_grant = 1'b0;
        cpu_op(0, 1, 8'h33, e, rd);
        idle(12);
        push(1, 14'h1239, 8'h33, cyc, "R8");
        slot_grant = 1'b1;
        idle(2);

        // R10 host strobe on the first eligible cycle cancels the slot
        cpu_op(0, 1, 8'h40, e, rd);
        idle(7);
        cpu_op(0, 1, 8'h44, e2, rd);
        chk("R10 timing", e2, e + 8);
        push(1, 14'h123A, 8'h44, e2 + 7, "R10");
        idle(10);

        // R4 colour memory select, R9 cleared by data access
        cpu_op(1, 1, 8'h00, e, rd);
        cpu_op(1, 1, 8'hC0, e, rd);
        chk("R4 cram_sel", {31'd0, cram_sel}, 1);
        chk("R4 no reg write", {31'd0, reg_we}, 0);
        cpu_op(0, 1, 8'h55, e, rd);
        chk("R9 cram cleared", {31'd0, cram_sel}, 0);
        push(1, 14'h123B, 8'h55, e + 7, "R4");
        idle(10);

        // R3 register write and index masking on both variants
        cpu_op(1, 1, 8'h9A, e, rd);
        cpu_op(1, 1, 8'h8B, e, rd);
        chk("R3 reg_we", {31'd0, reg_we}, 1);
        chk("R3 reg_idx", {28'd0, reg_idx}, 32'hB);
        chk("R3 reg_val", {24'd0, reg_val}, 32'h9A);
        chk("R3 classic idx", {28'd0, c_ridx}, 32'h3);
        idle(1);
        chk("R3 pulse", {31'd0, reg_we}, 0);

        // R9 lone first byte then data write resets pairing
        cpu_op(1, 1, 8'h77, e, rd);
        cpu_op(0, 1, 8'h66, e, rd);
        push(1, 14'h123C, 8'h66, e + 7, "R9");
        idle(10);
        cpu_op(1, 1, 8'h00, e, rd);
        cpu_op(1, 1, 8'h05, e, rd);
        push(0, 14'h0500, 8'h00, e + 7, "R9");
        idle(10);

        // R11 address wrap
        cpu_op(1, 1, 8'hFF, e, rd);
        cpu_op(1, 1, 8'h3F, e, rd);
        push(0, 14'h3FFF, 8'h00, e + 7, "R11");
        idle(10);
        cpu_op(0, 0, 8'h00, e, rd);
        chk("R11 rdata", {24'd0, rd}, 32'hA5);
        push(0, 14'h0000, 8'h00, e + 7, "R11");
        idle(10);
        cpu_op(0, 0, 8'h00, e, rd);
        chk("R11 rdata wrapped", {24'd0, rd}, 32'h5A);
        push(0, 14'h0001, 8'h00, e + 7, "R11");
        idle(10);

        // R7 classic variant waits one cycle longer
        cpu_op(1, 1, 8'h10, e, rd);
        cpu_op(1, 1, 8'h02, e, rd);
        push(0, 14'h0210, 8'h00, e + 7, "R7");
        idle(7);
        @(negedge clk);
        chk("R7 classic early", {31'd0, c_re}, 0);
        @(posedge clk); #1;
        @(negedge clk);
        chk("R7 classic served", {31'd0, c_re}, 1);
        chk("R7 classic addr", {18'd0, c_addr}, 32'h0210);
        @(posedge clk); #1;
        idle(5);

        chk("R8 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule